// File: doc/BRIEF.md
# PCI Bus-Master Address Phase Sequencer

This block is the front end of a PCI bus master. A local client asks for the bus with an active-low request. It also presents a 64-bit target address, a 4-bit bus command and a flag that says whether the transaction wants the 64-bit lanes. The sequencer raises REQ# to the arbiter. It waits until it holds the grant and sees an idle bus, then drives one or two address phases on AD and C/BE with FRAME# asserted. When the address phases are over, it reports completion to the local side with a one-cycle pulse.

A plain address phase is used when the upper 32 address bits are zero. Otherwise the block issues a dual-address cycle: the low word goes out with the dual-address command, and the high word follows with the real command. The upper lanes (AD[63:32], C/BE[7:4]) exist only when the block is built wide. A narrow build never enables them. Every output comes from a register clocked on the rising edge of the PCI clock.

Top module: `pci_addr_seq`

## Requirements
- R1: While rst_n is low at a rising edge, after that edge req_n and frame_n are 1, frame_oe, lane_oe_lo, lane_oe_hi and addr_done are 0, and ad and cbe are all zero.
- R2: When the sequencer is idle and samples lreq_n low, it captures laddr, lcmd and lwide and drives req_n low from the next cycle on. A low lreq_n sampled while a request is in progress has no effect on that transaction's address or command.
- R3: The first address phase starts only after an edge where gnt_n is 0 and frame_n_in and irdy_n_in are both 1. While that condition is missing (grant absent or withdrawn, or bus busy), frame_n stays 1 and req_n stays 0.
- R4: When laddr[63:32] is zero, a single address phase lasts one cycle. In it frame_n is 0, frame_oe and lane_oe_lo are 1, ad[31:0] equals laddr[31:0] and cbe[3:0] equals lcmd.
- R5: When laddr[63:32] is nonzero, the first of two consecutive address phases drives ad[31:0] with laddr[31:0] and cbe[3:0] with the dual-address code 4'b1101. 4'b1101 is not accepted as a transaction command.
- R6: In the second dual-address phase, frame_n is still 0, ad[31:0] equals laddr[63:32] and cbe[3:0] equals lcmd.
- R7: In a wide build (WIDE_EN=1), lane_oe_hi is 1 only during dual-address phases of a request with lwide=1. In those phases ad[63:32] equals laddr[63:32] and cbe[7:4] equals lcmd, held the same in both phases. Otherwise the upper lanes are zero and disabled. In a narrow build (WIDE_EN=0) they are always zero and disabled.
- R8: req_n returns to 1 in the cycle that frame_n first goes to 0.
- R9: In the cycle after the last address phase, addr_done is 1 for exactly one cycle, frame_n is driven 1 with frame_oe 1, and both lane enables are 0. In the following cycle frame_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | PCI clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| lreq_n | input | 1 | Local master request, active low |
| laddr | input | 64 | Target address from the local side |
| lcmd | input | 4 | PCI bus command for the transaction |
| lwide | input | 1 | Transaction uses the 64-bit lanes |
| gnt_n | input | 1 | Grant from the bus arbiter, active low |
| frame_n_in | input | 1 | Sampled bus FRAME# |
| irdy_n_in | input | 1 | Sampled bus IRDY# |
| req_n | output | 1 | Bus request to the arbiter, active low |
| frame_n | output | 1 | FRAME# output value |
| frame_oe | output | 1 | FRAME# output enable |
| ad | output | 64 | AD output value |
| cbe | output | 8 | C/BE output value |
| lane_oe_lo | output | 1 | Enable for AD[31:0] and C/BE[3:0] |
| lane_oe_hi | output | 1 | Enable for AD[63:32] and C/BE[7:4] |
| addr_done | output | 1 | One-cycle pulse after the address phases |

## Verification
The bench builds two copies from the same stimulus. `uut` has WIDE_EN=1 and `uut32` has WIDE_EN=0, both with LANE_W=32. The wide copy brings the upper-lane behaviour of dual-address cycles into reach for both values of lwide. The narrow copy shows that the same request pattern never enables or drives the extension lanes while the low lanes still carry both dual-address phases. Random wait patterns (grant missing, FRAME# busy, IRDY# busy) exercise the start condition, and a new request placed during the address phases exercises the capture rule.

// File: rtl/pci_addr_seq_pkg.sv
// Package: shared state encoding and the dual-address command code for the
// PCI master address-phase sequencer.
package pci_addr_seq_pkg;

    // Sequencer states, one per bus-visible step of a request.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_ADR1 = 3'd2,
        ST_ADR2 = 3'd3,
        ST_TURN = 3'd4
    } seq_state_t;

    // C/BE code marking the first phase of a dual-address cycle.
    localparam logic [3:0] CMD_DUAL_ADDR = 4'b1101;

endpackage

// File: rtl/pci_bus_idle_mon.sv
// Module: pci_bus_idle_mon
// Decides at each edge whether an address phase may begin. That needs a grant
// from the arbiter and an idle bus (FRAME# and IRDY# both high on the same edge).
// Assumes the inputs are already synchronous to clk.
module pci_bus_idle_mon (
    input  logic gnt_n,
    input  logic frame_n_in,
    input  logic irdy_n_in,
    output logic bus_idle,
    output logic may_start
);

    // Idle bus plus grant gives permission to start.
    always_comb begin
        bus_idle  = frame_n_in & irdy_n_in;
        may_start = bus_idle & ~gnt_n;
    end

endmodule

// File: rtl/pci_req_capture.sv
// Module: pci_req_capture
// Holds the address, command and lane width of the accepted request. Flags
// whether a dual-address cycle is needed (nonzero upper address word).
// Assumes cap_en is asserted only while the sequencer is idle.
module pci_req_capture #(
    parameter int LANE_W = 32,
    localparam int ADDR_W = 2 * LANE_W,
    localparam int CBE_W  = LANE_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [ADDR_W-1:0] laddr,
    input  logic [CBE_W-1:0]  lcmd,
    input  logic              lwide,
    output logic [LANE_W-1:0] addr_lo,
    output logic [LANE_W-1:0] addr_hi,
    output logic [CBE_W-1:0]  cmd,
    output logic              wide_req,
    output logic              is_dac
);

    // Register the request fields when the sequencer accepts a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo  <= '0;
            addr_hi  <= '0;
            cmd      <= '0;
            wide_req <= 1'b0;
        end else if (cap_en) begin
            addr_lo  <= laddr[LANE_W-1:0];
            addr_hi  <= laddr[ADDR_W-1:LANE_W];
            cmd      <= lcmd;
            wide_req <= lwide;
        end
    end

    // A nonzero upper word needs the two-phase dual-address cycle.
    assign is_dac = |addr_hi;

endmodule

// File: rtl/pci_addr_fsm.sv
// Module: pci_addr_fsm
// Sequences one request: bus request, wait for grant and idle bus, one or two
// address phases, then a release cycle with FRAME# driven high. Registers
// REQ#, FRAME#, its enable and the done pulse. Tells the lane driver which
// phase comes next. Assumes lreq_n is synchronous to clk.
module pci_addr_fsm
    import pci_addr_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lreq_n,
    input  logic may_start,
    input  logic is_dac,
    output logic cap_en,
    output logic nxt_ph1,
    output logic nxt_ph2,
    output logic req_n,
    output logic frame_n,
    output logic frame_oe,
    output logic addr_done
);

    seq_state_t state_q;
    seq_state_t state_d;

    // Next-state choice and capture strobe.
    always_comb begin
        state_d = state_q;
        cap_en  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (!lreq_n) begin
                    state_d = ST_REQ;
                    cap_en  = 1'b1;
                end
            end
            ST_REQ:  if (may_start) state_d = ST_ADR1;
            ST_ADR1: state_d = is_dac ? ST_ADR2 : ST_TURN;
            ST_ADR2: state_d = ST_TURN;
            ST_TURN: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    assign nxt_ph1 = (state_d == ST_ADR1);
    assign nxt_ph2 = (state_d == ST_ADR2);

    // State register and registered control outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            req_n     <= 1'b1;
            frame_n   <= 1'b1;
            frame_oe  <= 1'b0;
            addr_done <= 1'b0;
        end else begin
            state_q   <= state_d;
            req_n     <= ~(state_d == ST_REQ);
            frame_n   <= ~(nxt_ph1 | nxt_ph2);
            frame_oe  <= nxt_ph1 | nxt_ph2 | (state_d == ST_TURN);
            addr_done <= (state_d == ST_TURN);
        end
    end

endmodule

// File: rtl/pci_lane_drv.sv
// Module: pci_lane_drv
// Registers the AD and C/BE lanes and their enables for the address phases.
// The low lane always exists. The high lane is built only when WIDE_EN is
// set; otherwise it is tied to zero and never enabled.
module pci_lane_drv
    import pci_addr_seq_pkg::*;
#(
    parameter int LANE_W  = 32,
    parameter bit WIDE_EN = 1'b1,
    localparam int CBE_W  = LANE_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nxt_ph1,
    input  logic              nxt_ph2,
    input  logic [LANE_W-1:0] addr_lo,
    input  logic [LANE_W-1:0] addr_hi,
    input  logic [CBE_W-1:0]  cmd,
    input  logic              wide_req,
    input  logic              is_dac,
    output logic [LANE_W-1:0] ad_lo,
    output logic [LANE_W-1:0] ad_hi,
    output logic [CBE_W-1:0]  cbe_lo,
    output logic [CBE_W-1:0]  cbe_hi,
    output logic              oe_lo,
    output logic              oe_hi
);

    localparam logic [CBE_W-1:0] DUAL_CODE = CBE_W'(CMD_DUAL_ADDR);

    // Low lane: low word plus dual code or command, then high word plus command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_lo  <= '0;
            cbe_lo <= '0;
            oe_lo  <= 1'b0;
        end else if (nxt_ph1) begin
            ad_lo  <= addr_lo;
            cbe_lo <= is_dac ? DUAL_CODE : cmd;
            oe_lo  <= 1'b1;
        end else if (nxt_ph2) begin
            ad_lo  <= addr_hi;
            cbe_lo <= cmd;
            oe_lo  <= 1'b1;
        end else begin
            ad_lo  <= '0;
            cbe_lo <= '0;
            oe_lo  <= 1'b0;
        end
    end

    generate
        if (WIDE_EN) begin : g_wide
            logic hi_act;
            assign hi_act = (nxt_ph1 | nxt_ph2) & is_dac & wide_req;

            // High lane: upper word and command through both dual phases.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ad_hi  <= '0;
                    cbe_hi <= '0;
                    oe_hi  <= 1'b0;
                end else if (hi_act) begin
                    ad_hi  <= addr_hi;
                    cbe_hi <= cmd;
                    oe_hi  <= 1'b1;
                end else begin
                    ad_hi  <= '0;
                    cbe_hi <= '0;
                    oe_hi  <= 1'b0;
                end
            end
        end else begin : g_narrow
            assign ad_hi  = '0;
            assign cbe_hi = '0;
            assign oe_hi  = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pci_addr_seq.sv
// Module: pci_addr_seq (top)
// PCI master front end: local request -> REQ#, grant and idle wait, single or
// dual-address phase on AD/C/BE with FRAME#, release cycle and done pulse.
// Assumes all inputs are synchronous to clk and that the pad ring applies
// the output enables.
module pci_addr_seq #(
    parameter int LANE_W  = 32,
    parameter bit WIDE_EN = 1'b1,
    localparam int ADDR_W = 2 * LANE_W,
    localparam int CBE_W  = LANE_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lreq_n,
    input  logic [ADDR_W-1:0] laddr,
    input  logic [CBE_W-1:0]  lcmd,
    input  logic              lwide,
    input  logic              gnt_n,
    input  logic              frame_n_in,
    input  logic              irdy_n_in,
    output logic              req_n,
    output logic              frame_n,
    output logic              frame_oe,
    output logic [ADDR_W-1:0] ad,
    output logic [2*CBE_W-1:0] cbe,
    output logic              lane_oe_lo,
    output logic              lane_oe_hi,
    output logic              addr_done
);

    logic              may_start;
    logic              bus_idle;
    logic              cap_en;
    logic              nxt_ph1;
    logic              nxt_ph2;
    logic [LANE_W-1:0] addr_lo;
    logic [LANE_W-1:0] addr_hi;
    logic [CBE_W-1:0]  cmd;
    logic              wide_req;
    logic              is_dac;
    logic [LANE_W-1:0] ad_lo;
    logic [LANE_W-1:0] ad_hi;
    logic [CBE_W-1:0]  cbe_lo;
    logic [CBE_W-1:0]  cbe_hi;

    pci_bus_idle_mon u_idle (
        .gnt_n      (gnt_n),
        .frame_n_in (frame_n_in),
        .irdy_n_in  (irdy_n_in),
        .bus_idle   (bus_idle),
        .may_start  (may_start)
    );

    pci_req_capture #(.LANE_W(LANE_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en),
        .laddr    (laddr),
        .lcmd     (lcmd),
        .lwide    (lwide),
        .addr_lo  (addr_lo),
        .addr_hi  (addr_hi),
        .cmd      (cmd),
        .wide_req (wide_req),
        .is_dac   (is_dac)
    );

    pci_addr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lreq_n    (lreq_n),
        .may_start (may_start & bus_idle),
        .is_dac    (is_dac),
        .cap_en    (cap_en),
        .nxt_ph1   (nxt_ph1),
        .nxt_ph2   (nxt_ph2),
        .req_n     (req_n),
        .frame_n   (frame_n),
        .frame_oe  (frame_oe),
        .addr_done (addr_done)
    );

    pci_lane_drv #(.LANE_W(LANE_W), .WIDE_EN(WIDE_EN)) u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_ph1  (nxt_ph1),
        .nxt_ph2  (nxt_ph2),
        .addr_lo  (addr_lo),
        .addr_hi  (addr_hi),
        .cmd      (cmd),
        .wide_req (wide_req),
        .is_dac   (is_dac),
        .ad_lo    (ad_lo),
        .ad_hi    (ad_hi),
        .cbe_lo   (cbe_lo),
        .cbe_hi   (cbe_hi),
        .oe_lo    (lane_oe_lo),
        .oe_hi    (lane_oe_hi)
    );

    assign ad  = {ad_hi, ad_lo};
    assign cbe = {cbe_hi, cbe_lo};

endmodule

// File: rtl/pci_addr_seq_chk.sv
// Module: pci_addr_seq_chk
// Checker for the address-phase sequencer, bound to every pci_addr_seq
// instance. Relates the bus-side outputs to the sampled bus inputs over time.
module pci_addr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       gnt_n,
    input logic       frame_n_in,
    input logic       irdy_n_in,
    input logic       req_n,
    input logic       frame_n,
    input logic       frame_oe,
    input logic [3:0] cbe_lo4,
    input logic       lane_oe_lo,
    input logic       lane_oe_hi,
    input logic       addr_done
);

    // R3
    start_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> $past(!gnt_n && frame_n_in && irdy_n_in));

    // R8
    req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(frame_n) |-> req_n);

    // R5
    dual_second_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(frame_n) && cbe_lo4 == 4'b1101) |=> (!frame_n && lane_oe_lo));

    // R7
    hi_lane_in_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lane_oe_hi |-> (!frame_n && lane_oe_lo));

    // R9
    done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |-> (frame_n && frame_oe && !lane_oe_lo && !lane_oe_hi));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done |=> (!addr_done && !frame_oe));

endmodule

bind pci_addr_seq pci_addr_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gnt_n      (gnt_n),
    .frame_n_in (frame_n_in),
    .irdy_n_in  (irdy_n_in),
    .req_n      (req_n),
    .frame_n    (frame_n),
    .frame_oe   (frame_oe),
    .cbe_lo4    (cbe[3:0]),
    .lane_oe_lo (lane_oe_lo),
    .lane_oe_hi (lane_oe_hi),
    .addr_done  (addr_done)
);

// File: tb/pci_addr_seq_test.sv
// Bench for pci_addr_seq: a wide and a narrow build driven by the same
// directed and seeded random requests, checked against bench-computed values.
module pci_addr_seq_test;

    localparam logic [3:0] DUAL = 4'b1101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lreq_n = 1'b1;
    logic [63:0] laddr = '0;
    logic [3:0]  lcmd = '0;
    logic        lwide = 1'b0;
    logic        gnt_n = 1'b1;
    logic        frame_n_in = 1'b1;
    logic        irdy_n_in = 1'b1;

    logic        req_n, frame_n, frame_oe, oe_lo, oe_hi, done;
    logic [63:0] ad;
    logic [7:0]  cbe;
    logic        n_req_n, n_frame_n, n_frame_oe, n_oe_lo, n_oe_hi, n_done;
    logic [63:0] n_ad;
    logic [7:0]  n_cbe;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    pci_addr_seq #(.LANE_W(32), .WIDE_EN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .lreq_n(lreq_n), .laddr(laddr), .lcmd(lcmd),
        .lwide(lwide), .gnt_n(gnt_n), .frame_n_in(frame_n_in), .irdy_n_in(irdy_n_in),
        .req_n(req_n), .frame_n(frame_n), .frame_oe(frame_oe), .ad(ad), .cbe(cbe),
        .lane_oe_lo(oe_lo), .lane_oe_hi(oe_hi), .addr_done(done)
    );

    pci_addr_seq #(.LANE_W(32), .WIDE_EN(1'b0)) uut32 (
        .clk(clk), .rst_n(rst_n), .lreq_n(lreq_n), .laddr(laddr), .lcmd(lcmd),
        .lwide(lwide), .gnt_n(gnt_n), .frame_n_in(frame_n_in), .irdy_n_in(irdy_n_in),
        .req_n(n_req_n), .frame_n(n_frame_n), .frame_oe(n_frame_oe), .ad(n_ad), .cbe(n_cbe),
        .lane_oe_lo(n_oe_lo), .lane_oe_hi(n_oe_hi), .addr_done(n_done)
    );

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Flag vector: {req_n, frame_n, frame_oe, lo_oe, hi_oe, done}
    function automatic logic [5:0] flags_w();
        return {req_n, frame_n, frame_oe, oe_lo, oe_hi, done};
    endfunction
    function automatic logic [5:0] flags_n();
        return {n_req_n, n_frame_n, n_frame_oe, n_oe_lo, n_oe_hi, n_done};
    endfunction

    // Expected low lane in address phase 1 or 2.
    function automatic logic [35:0] exp_lo(input logic [63:0] a, input logic [3:0] c, input bit ph2);
        bit dac = (a[63:32] != 0);
        if (ph2) return {c, a[63:32]};
        return {dac ? DUAL : c, a[31:0]};
    endfunction

    // Expected high lane (wide build) during address phases.
    function automatic logic [36:0] exp_hi(input logic [63:0] a, input logic [3:0] c, input bit w);
        if (a[63:32] != 0 && w) return {1'b1, c, a[63:32]};
        return '0;
    endfunction

    // Check both builds during an address phase.
    task automatic chk_phase(input logic [63:0] a, input logic [3:0] c, input bit w, input bit ph2, input string tag);
        logic [36:0] hi = exp_hi(a, c, w);
        chk({cbe[3:0], ad[31:0]} == exp_lo(a, c, ph2), tag, {28'd0, cbe[3:0], ad[31:0]}, {28'd0, exp_lo(a, c, ph2)});
        chk({n_cbe[3:0], n_ad[31:0]} == exp_lo(a, c, ph2), tag, {28'd0, n_cbe[3:0], n_ad[31:0]}, {28'd0, exp_lo(a, c, ph2)});
        chk(flags_w() == {1'b1, 1'b0, 1'b1, 1'b1, hi[36], 1'b0}, {tag, " R8 flags"}, 64'(flags_w()), 64'({4'b1011, hi[36], 1'b0}));
        chk(flags_n() == 6'b101100, {tag, " R8 narrow flags"}, 64'(flags_n()), 64'(6'b101100));
        chk({oe_hi, cbe[7:4], ad[63:32]} == hi, "R7 wide upper lanes", {27'd0, oe_hi, cbe[7:4], ad[63:32]}, {27'd0, hi});
        chk({n_oe_hi, n_cbe[7:4], n_ad[63:32]} == '0, "R7 narrow upper lanes", {27'd0, n_oe_hi, n_cbe[7:4], n_ad[63:32]}, 64'd0);
    endtask

    // Run one transaction with 'waits' not-ready cycles (pattern chosen by pat).
    task automatic run_txn(input logic [63:0] a, input logic [3:0] c, input bit w, input int waits, input int pat);
        bit dac = (a[63:32] != 0);
        @(negedge clk);
        lreq_n = 1'b0; laddr = a; lcmd = c; lwide = w;
        gnt_n = 1'b1; frame_n_in = 1'b1; irdy_n_in = 1'b1;
        @(negedge clk);
        lreq_n = 1'b1; laddr = ~a; lcmd = ~c;
        chk(flags_w() == 6'b010000, "R2 request raised", 64'(flags_w()), 64'(6'b010000));
        chk(flags_n() == 6'b010000, "R2 narrow request raised", 64'(flags_n()), 64'(6'b010000));
        for (int i = 0; i < waits; i++) begin
            int p = (pat >= 0) ? pat : int'($urandom % 3);
            case (p)
                0: begin gnt_n = 1'b1; frame_n_in = 1'b1; irdy_n_in = 1'b1; end
                1: begin gnt_n = 1'b0; frame_n_in = 1'b0; irdy_n_in = 1'b1; end
                default: begin gnt_n = 1'b0; frame_n_in = 1'b1; irdy_n_in = 1'b0; end
            endcase
            @(negedge clk);
            chk(flags_w() == 6'b010000, "R3 waiting", 64'(flags_w()), 64'(6'b010000));
            chk(flags_n() == 6'b010000, "R3 narrow waiting", 64'(flags_n()), 64'(6'b010000));
        end
        gnt_n = 1'b0; frame_n_in = 1'b1; irdy_n_in = 1'b1;
        @(negedge clk);
        chk_phase(a, c, w, 1'b0, dac ? "R5 dual phase 1" : "R4 single phase");
        // New request during the address phase must not disturb it.
        lreq_n = 1'b0; laddr = 64'hFFFF_FFFF_0000_0000 ^ a; lcmd = c ^ 4'h1;
        gnt_n = 1'b1;
        if (dac) begin
            @(negedge clk);
            lreq_n = 1'b1;
            chk_phase(a, c, w, 1'b1, "R6 dual phase 2 (R2 ignore)");
        end
        @(negedge clk);
        lreq_n = 1'b1;
        chk(flags_w() == 6'b111001, "R9 release cycle", 64'(flags_w()), 64'(6'b111001));
        chk(flags_n() == 6'b111001, "R9 narrow release cycle", 64'(flags_n()), 64'(6'b111001));
        chk(ad == 0 && cbe == 0, "R9 lanes cleared", ad, 64'd0);
        @(negedge clk);
        chk(flags_w() == 6'b110000, "R9 after release", 64'(flags_w()), 64'(6'b110000));
        chk(flags_n() == 6'b110000, "R9 narrow after release", 64'(flags_n()), 64'(6'b110000));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(flags_w() == 6'b110000 && ad == 0 && cbe == 0, "R1 reset state", 64'(flags_w()), 64'(6'b110000));
        chk(flags_n() == 6'b110000 && n_ad == 0 && n_cbe == 0, "R1 narrow reset state", 64'(flags_n()), 64'(6'b110000));
        rst_n = 1'b1;
        // Directed corner cases.
        run_txn(64'h0000_0000_1234_5678, 4'h7, 1'b0, 0, 0);
        run_txn(64'h0000_0000_89AB_CDEF, 4'h6, 1'b1, 3, 0);
        run_txn(64'h0000_0001_0000_0000, 4'h7, 1'b1, 2, 1);
        run_txn(64'hDEAD_BEEF_CAFE_F00D, 4'hC, 1'b0, 2, 2);
        run_txn(64'hFFFF_FFFF_FFFF_FFFF, 4'hF, 1'b1, 1, 0);
        // Seeded random transactions.
        for (int n = 0; n < 40; n++) begin
            logic [63:0] a;
            logic [3:0]  c;
            a = {($urandom % 2) ? $urandom : 32'd0, $urandom};
            c = 4'($urandom % 16);
            if (c == DUAL) c = 4'h7;
            run_txn(a, c, 1'($urandom % 2), int'($urandom % 5), -1);
        end
        summary();
        $finish;
    end

endmodule